// File: doc/BRIEF.md
# Period-Counting Frequency Meter

This block measures an external digital clock by counting how many system-clock cycles pass between two consecutive rising edges of that input. The asynchronous input is resampled through a short synchronizer on every system clock, and a rising edge is recognised when a low sample is followed by a high one. Each time an edge closes a full period, the finished count leaves as one word on a valid/ready stream that feeds a host-bound FIFO. With a 40 MHz system clock, the input frequency is 40,000,000 divided by the word.

The host starts and stops the stream with a level enable. After the enable rises, the first edge only arms the meter, so every word that is sent covers a complete period. The counter never stalls. If the stream still holds an unaccepted word when a new count completes, the new count is dropped and a sticky overrun flag is raised. If no edge arrives for long enough, the counter stops at all-ones and a sticky timeout flag is raised.

Top module: `period_meter`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the armed state, `m_valid`, `m_data`, `timeout` and `overrun` all clear to zero.
- R2: `sig_in` passes through a two-stage synchronizer, and a rising edge is a low sample followed by a high sample. When `sig_in` is driven high between two clock edges, the resulting word shows on `m_valid`/`m_data` after the third rising clock edge that follows, and not earlier.
- R3: Each word on `m_data` equals the number of system-clock cycles between two consecutive detected rising edges of `sig_in`.
- R4: The first rising edge detected after `enable` goes high only arms the meter and produces no word. Each later edge while `enable` stays high produces exactly one word.
- R5: While `enable` is low, no word is pushed and the armed state is cleared.
- R6: Once `m_valid` is high, it stays high and `m_data` stays unchanged until a cycle in which `m_ready` is high.
- R7: If a count completes while `m_valid` is high and `m_ready` is low, that count is dropped, the held word is kept, and `overrun` goes high. `overrun` stays high until reset or until `enable` is low.
- R8: The counter saturates at all-ones (2^CNT_W-1). `timeout` goes high when the count reaches all-ones while `enable` is high. The word for that period is all-ones. `timeout` clears on the next detected edge or when `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Host run control; high lets period words be sent |
| sig_in | input | 1 | Asynchronous input whose period is measured |
| m_valid | output | 1 | Stream word present |
| m_ready | input | 1 | Downstream FIFO accepts the word |
| m_data | output | CNT_W | Period length in system-clock cycles |
| timeout | output | 1 | Sticky flag: no edge before the counter saturated |
| overrun | output | 1 | Sticky flag: a completed count was dropped |

## Verification
A rise on `sig_in` driven at a falling clock edge first shows on the stream after the third rising clock edge that follows. The bench checks that timing once, with a direct check two and three cycles after the drive. In every other case the word is compared with the gap between the bench's own driven edges. That gap is immune to the fixed synchronizer delay, so each expected period is queued when its edge is driven and is popped when a handshake is seen one time step after a falling edge. The sticky flags are read a few cycles after the event that sets or clears them, once their single register stage has long settled.

// File: rtl/period_meter.sv
module period_meter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sig_in,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [CNT_W-1:0] m_data,
  output logic             timeout,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES:0] smp;
  logic [CNT_W-1:0]     cnt;
  logic                 armed;
  logic                 rise, sat, take, slot_free;

  assign rise      = smp[SYNC_STAGES-1] & ~smp[SYNC_STAGES];
  assign sat       = (cnt == CNT_MAX);
  assign take      = rise & armed & enable;
  assign slot_free = ~m_valid | m_ready;

  always_ff @(posedge clk) begin
    if (rst) smp <= '0;
    else     smp <= {smp[SYNC_STAGES-1:0], sig_in};
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (rise) cnt <= CNT_W'(1);
    else if (!sat) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (!enable) armed <= 1'b0;
    else if (rise)    armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (take && slot_free) begin
      m_valid <= 1'b1;
      m_data  <= cnt;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable)        overrun <= 1'b0;
    else if (take && !slot_free) overrun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) timeout <= 1'b0;
    else if (rise)      timeout <= 1'b0;
    else if (sat)       timeout <= 1'b1;
  end

  a_r5_push_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(enable));
  a_r5_disarm: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !armed);
  a_r6_hold_word: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready && take) |=> overrun);
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (sat && !rise) |=> (cnt == CNT_MAX));
  a_r8_timeout_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !timeout);

endmodule

// File: tb/test_period_meter.sv
`timescale 1ns/1ps
module test_period_meter;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst = 1, enable = 0, sig_in = 0, m_ready = 1;
  logic m_valid, timeout, overrun;
  logic [W-1:0] m_data;
  int checks = 0, fails = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  period_meter #(.CNT_W(W)) i_period_meter (
    .clk(clk), .rst(rst), .enable(enable), .sig_in(sig_in),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .timeout(timeout), .overrun(overrun));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic hold(input logic lvl, input int n);
    sig_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  // R3, R4: pop expected period on each handshake
  always begin
    @(negedge clk); #1;
    if (!rst && m_valid && m_ready) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected word", int'(m_data), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(m_data) == e, "R3 period word", int'(m_data), e);
      end
    end
  end

  task automatic burst(input int n);
    enable = 1;
    hold(0, 3);
    for (int i = 0; i < n; i++) begin
      int h, l;
      h = rnd(1, 20);
      l = rnd(1, 20);
      if (i < n - 1) exp_q.push_back(h + l);
      hold(1, h);
      hold(0, l);
    end
    hold(0, 6);
    chk(exp_q.size() == 0, "R4 words per burst", exp_q.size(), 0);
    exp_q.delete();
    enable = 0;
    hold(0, 2);
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(m_valid == 0, "R1 m_valid", m_valid, 0);
    chk(m_data == 0, "R1 m_data", m_data, 0);
    chk(timeout == 0 && overrun == 0, "R1 flags", {timeout, overrun}, 0);
    rst = 0;
    @(negedge clk);

    // R2 latency, R4 first edge arms only
    enable = 1;
    hold(0, 3);
    hold(1, 3);
    hold(0, 5);
    chk(m_valid == 0, "R4 arm edge no word", m_valid, 0);
    exp_q.push_back(8);
    sig_in = 1;
    @(negedge clk); @(negedge clk); #0.5;
    chk(m_valid == 0, "R2 not before third edge", m_valid, 0);
    @(negedge clk); #0.5;
    chk(m_valid == 1, "R2 word after third edge", m_valid, 1);
    chk(m_data == 8, "R2 latency word", m_data, 8);
    hold(1, 2);
    hold(0, 4);
    enable = 0;
    hold(0, 2);
    exp_q.delete();

    // R5: disabled, edges produce nothing
    for (int i = 0; i < 6; i++) begin
      hold(1, 3);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #1;
        chk(m_valid == 0, "R5 no push while disabled", m_valid, 0);
      end
      sig_in = 0;
    end

    // R3, R4: random periods
    for (int b = 0; b < 12; b++) burst(rnd(2, 10));

    // R6, R7: backpressure overrun
    m_ready = 0;
    enable = 1;
    hold(0, 3);
    hold(1, 2); hold(0, 5);
    hold(1, 3); hold(0, 3);
    hold(1, 1); hold(0, 2);
    hold(0, 5);
    chk(m_valid == 1, "R6 word held", m_valid, 1);
    chk(m_data == 7, "R7 first word kept", m_data, 7);
    chk(overrun == 1, "R7 overrun set", overrun, 1);
    exp_q.push_back(7);
    m_ready = 1;
    hold(0, 4);
    chk(exp_q.size() == 0, "R7 dropped word absent", exp_q.size(), 0);
    chk(overrun == 1, "R7 overrun sticky", overrun, 1);
    enable = 0;
    hold(0, 2);
    chk(overrun == 0, "R7 overrun clear on disable", overrun, 0);

    // R8: saturation and timeout
    enable = 1;
    hold(0, 3);
    hold(1, 2);
    hold(0, 300);
    chk(timeout == 1, "R8 timeout set", timeout, 1);
    chk(m_valid == 0, "R8 no word during stall", m_valid, 0);
    exp_q.push_back(MAXV);
    hold(1, 2);
    hold(0, 5);
    chk(exp_q.size() == 0, "R8 saturated word", exp_q.size(), 0);
    chk(timeout == 0, "R8 timeout clear on edge", timeout, 0);
    hold(0, 300);
    chk(timeout == 1, "R8 timeout set again", timeout, 1);
    enable = 0;
    hold(0, 2);
    chk(timeout == 0, "R8 timeout clear on disable", timeout, 0);

    // R1: reset mid-run
    enable = 1;
    m_ready = 0;
    hold(0, 3);
    hold(1, 2); hold(0, 3); hold(1, 2); hold(0, 4);
    rst = 1;
    hold(0, 2);
    chk(m_valid == 0 && overrun == 0 && timeout == 0, "R1 reset clears", {m_valid, overrun, timeout}, 0);
    rst = 0;
    m_ready = 1;
    exp_q.delete();
    enable = 0;
    hold(0, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule